// File: doc/BRIEF.md
# Half-Word Staggered Adder with Forwarding

This block is a 32-bit integer adder that is sliced in time into three phases on a fast clock. In the first phase the lower 16 bits are summed. In the second phase the upper 16 bits are summed, using the carry that the first phase registered. In the third phase the condition flags are formed. The lower half of a sum is ready one cycle after issue. It can serve as an early index for a lookup, while the upper half arrives one cycle later for the slower comparison.

Each operand carries a forwarding select. When a select is set, that operand takes the result of the most recent valid add instead of the value on its input port. Each half comes from the slice register that produced it. The lower half is forwarded into a new add's first phase, and the upper half into its second phase. Two dependent adds can therefore issue in consecutive cycles without waiting for the full 32-bit result. A valid bit travels with each phase. A phase that carries no operation leaves its outputs unchanged.

Top module: `stg_add_top`

## Requirements
- R1: While reset is high and after it, with no issue yet, every valid output is 0 and lo_sum, res_sum and flg_out are all zero.
- R2: One cycle after an issue, lo_valid is 1 and lo_sum equals bits 15:0 of the sum of the two effective operands.
- R3: Two cycles after an issue, res_valid is 1 and res_sum equals the 32-bit sum of the effective operands, with its lower half equal to the lo_sum shown one cycle earlier.
- R4: Three cycles after an issue, flg_valid is 1. flg_out is then laid out as bit 3 zero (sum is 0), bit 2 sign (sum bit 31), bit 1 carry (carry out of bit 31) and bit 0 overflow (signed overflow: the operands share a sign that differs from the sum's sign).
- R5: With iss_a_byp (or iss_b_byp) at 1, operand A (or B) is the 32-bit result of the most recent earlier valid issue, even if idle cycles lie between, and the port value is ignored. After reset with no earlier issue this value is 0.
- R6: A chain of dependent adds issued in consecutive cycles, each forwarding the previous result, yields the correct running sum for every link.
- R7: A cycle without iss_valid makes the matching valid output 0 in each later phase and leaves lo_sum, res_sum and flg_out holding their previous values.
- R8: With both selects at 1, the add doubles the previous result.
- R9: A carry out of the lower half is applied to the upper half, including the wrap of all ones plus one to zero with carry set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An add is issued this cycle |
| iss_a | input | 32 | Operand A from the register path |
| iss_b | input | 32 | Operand B from the register path |
| iss_a_byp | input | 1 | Operand A takes the forwarded result |
| iss_b_byp | input | 1 | Operand B takes the forwarded result |
| lo_valid | output | 1 | Lower-half phase holds a new result |
| lo_sum | output | 16 | Lower 16 bits of the sum, early |
| res_valid | output | 1 | Upper-half phase holds a new result |
| res_sum | output | 32 | Full 32-bit sum |
| flg_valid | output | 1 | Flag phase holds new flags |
| flg_out | output | 4 | Flags: zero, sign, carry, overflow (bits 3..0) |

## Verification
In one cycle the lower-half add of a new operation runs alongside the upper-half add of the operation it depends on. The upper half must then pick up the producer's upper half in the very phase in which that half is written. Random streams with dense back-to-back issues and forwarding selects provoke this overlap. Directed chains and doubling runs provoke it on purpose, and idle gaps are placed between producer and consumer. Each phase output is compared every cycle against a bench model that tracks the last valid result and shifts expected values through three stages.

// File: rtl/stg_add_pkg.sv
package stg_add_pkg;

    localparam int FLAG_W    = 4;
    localparam int FLG_ZERO  = 3;
    localparam int FLG_SIGN  = 2;
    localparam int FLG_CARRY = 1;
    localparam int FLG_OVF   = 0;

    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
        logic ovf;
    } flags_t;

    // signed overflow from the sign bits of both operands and the sum
    function automatic logic signed_ovf(input logic a_msb, input logic b_msb,
                                        input logic s_msb);
        return (a_msb == b_msb) && (s_msb != a_msb);
    endfunction

endpackage

// File: rtl/stg_lo_slice.sv
module stg_lo_slice #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    input  logic          a_byp,
    input  logic          b_byp,
    output logic          out_valid,
    output logic [SW-1:0] sum_q,
    output logic          carry_q,
    output logic          zero_q
);

    logic [SW-1:0] opa, opb;
    logic [SW:0]   wide;

    // the forwarded lower half is this slice's own registered sum
    always_comb begin
        opa  = a_byp ? sum_q : a;
        opb  = b_byp ? sum_q : b;
        wide = {1'b0, opa} + {1'b0, opb};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sum_q     <= '0;
            carry_q   <= 1'b0;
            zero_q    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum_q   <= wide[SW-1:0];
                carry_q <= wide[SW];
                zero_q  <= (wide[SW-1:0] == '0);
            end
        end
    end

endmodule

// File: rtl/stg_hi_slice.sv
module stg_hi_slice #(
    parameter int SW = 16,
    localparam int DW = 2 * SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iss_valid,
    input  logic [SW-1:0] a_hi,
    input  logic [SW-1:0] b_hi,
    input  logic          a_byp,
    input  logic          b_byp,
    input  logic          lo_valid,
    input  logic [SW-1:0] lo_sum,
    input  logic          lo_carry,
    input  logic          lo_zero,
    output logic          out_valid,
    output logic [DW-1:0] sum_q,
    output logic          carry_q,
    output logic          ovf_q,
    output logic          zero_lo_q,
    output logic          zero_hi_q
);

    typedef struct packed {
        logic [SW-1:0] a;
        logic [SW-1:0] b;
        logic          a_byp;
        logic          b_byp;
    } hi_req_t;

    hi_req_t       req_q;
    logic [SW-1:0] opa, opb;
    logic [SW:0]   wide;

    // stage 1: park the upper operands until the lower carry is ready
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (iss_valid) begin
            req_q <= '{a: a_hi, b: b_hi, a_byp: a_byp, b_byp: b_byp};
        end
    end

    // stage 2: forwarded upper half comes from this slice's own register
    always_comb begin
        opa  = req_q.a_byp ? sum_q[DW-1:SW] : req_q.a;
        opb  = req_q.b_byp ? sum_q[DW-1:SW] : req_q.b;
        wide = {1'b0, opa} + {1'b0, opb} + {{SW{1'b0}}, lo_carry};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sum_q     <= '0;
            carry_q   <= 1'b0;
            ovf_q     <= 1'b0;
            zero_lo_q <= 1'b0;
            zero_hi_q <= 1'b0;
        end else begin
            out_valid <= lo_valid;
            if (lo_valid) begin
                sum_q     <= {wide[SW-1:0], lo_sum};
                carry_q   <= wide[SW];
                ovf_q     <= stg_add_pkg::signed_ovf(opa[SW-1], opb[SW-1], wide[SW-1]);
                zero_lo_q <= lo_zero;
                zero_hi_q <= (wide[SW-1:0] == '0);
            end
        end
    end

endmodule

// File: rtl/stg_flag_unit.sv
module stg_flag_unit (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                sign,
    input  logic                carry,
    input  logic                ovf,
    input  logic                zero_lo,
    input  logic                zero_hi,
    output logic                out_valid,
    output stg_add_pkg::flags_t flags_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            flags_q   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                flags_q <= '{zero: zero_lo & zero_hi, sign: sign,
                             carry: carry, ovf: ovf};
            end
        end
    end

endmodule

// File: rtl/stg_add_top.sv
module stg_add_top #(
    parameter int SW = 16,
    localparam int DW = 2 * SW
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          iss_valid,
    input  logic [DW-1:0]                 iss_a,
    input  logic [DW-1:0]                 iss_b,
    input  logic                          iss_a_byp,
    input  logic                          iss_b_byp,
    output logic                          lo_valid,
    output logic [SW-1:0]                 lo_sum,
    output logic                          res_valid,
    output logic [DW-1:0]                 res_sum,
    output logic                          flg_valid,
    output logic [stg_add_pkg::FLAG_W-1:0] flg_out
);

    logic                lo_carry, lo_zero;
    logic                hi_carry, hi_ovf, hi_zero_lo, hi_zero_hi;
    stg_add_pkg::flags_t flags;

    stg_lo_slice #(.SW(SW)) u_lo (
        .clk      (clk),
        .rst      (rst),
        .in_valid (iss_valid),
        .a        (iss_a[SW-1:0]),
        .b        (iss_b[SW-1:0]),
        .a_byp    (iss_a_byp),
        .b_byp    (iss_b_byp),
        .out_valid(lo_valid),
        .sum_q    (lo_sum),
        .carry_q  (lo_carry),
        .zero_q   (lo_zero)
    );

    stg_hi_slice #(.SW(SW)) u_hi (
        .clk      (clk),
        .rst      (rst),
        .iss_valid(iss_valid),
        .a_hi     (iss_a[DW-1:SW]),
        .b_hi     (iss_b[DW-1:SW]),
        .a_byp    (iss_a_byp),
        .b_byp    (iss_b_byp),
        .lo_valid (lo_valid),
        .lo_sum   (lo_sum),
        .lo_carry (lo_carry),
        .lo_zero  (lo_zero),
        .out_valid(res_valid),
        .sum_q    (res_sum),
        .carry_q  (hi_carry),
        .ovf_q    (hi_ovf),
        .zero_lo_q(hi_zero_lo),
        .zero_hi_q(hi_zero_hi)
    );

    stg_flag_unit u_flg (
        .clk      (clk),
        .rst      (rst),
        .in_valid (res_valid),
        .sign     (res_sum[DW-1]),
        .carry    (hi_carry),
        .ovf      (hi_ovf),
        .zero_lo  (hi_zero_lo),
        .zero_hi  (hi_zero_hi),
        .out_valid(flg_valid),
        .flags_q  (flags)
    );

    assign flg_out = flags;

endmodule

// File: rtl/stg_add_checker.sv
module stg_add_checker #(
    parameter int SW = 16,
    localparam int DW = 2 * SW
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           iss_valid,
    input logic                           lo_valid,
    input logic [SW-1:0]                  lo_sum,
    input logic                           res_valid,
    input logic [DW-1:0]                  res_sum,
    input logic                           flg_valid,
    input logic [stg_add_pkg::FLAG_W-1:0] flg_out
);

    assert_issue_to_lo_R2: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> lo_valid);

    assert_lo_to_res_R3: assert property (@(posedge clk) disable iff (rst)
        lo_valid |=> res_valid);

    assert_low_half_kept_R3: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_sum[SW-1:0] == $past(lo_sum));

    assert_res_to_flag_R4: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> flg_valid);

    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
        flg_valid |-> flg_out[stg_add_pkg::FLG_ZERO] == ($past(res_sum) == '0));

    assert_sign_flag_R4: assert property (@(posedge clk) disable iff (rst)
        flg_valid |-> flg_out[stg_add_pkg::FLG_SIGN] == $past(res_sum[DW-1]));

    assert_idle_res_R7: assert property (@(posedge clk) disable iff (rst)
        !lo_valid |=> !res_valid);

    assert_idle_flag_R7: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> !flg_valid);

    assert_hold_lo_R7: assert property (@(posedge clk) disable iff (rst)
        !lo_valid |-> $stable(lo_sum));

    assert_hold_res_R7: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res_sum));

endmodule

bind stg_add_top stg_add_checker #(.SW(SW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .iss_valid(iss_valid),
    .lo_valid (lo_valid),
    .lo_sum   (lo_sum),
    .res_valid(res_valid),
    .res_sum  (res_sum),
    .flg_valid(flg_valid),
    .flg_out  (flg_out)
);

// File: tb/stg_add_top_bench.sv
module stg_add_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        iss_valid, iss_a_byp, iss_b_byp;
    logic [31:0] iss_a, iss_b;
    logic        lo_valid, res_valid, flg_valid;
    logic [15:0] lo_sum;
    logic [31:0] res_sum;
    logic [3:0]  flg_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    stg_add_top u_stg_add_top (
        .clk(clk), .rst(rst), .iss_valid(iss_valid),
        .iss_a(iss_a), .iss_b(iss_b),
        .iss_a_byp(iss_a_byp), .iss_b_byp(iss_b_byp),
        .lo_valid(lo_valid), .lo_sum(lo_sum),
        .res_valid(res_valid), .res_sum(res_sum),
        .flg_valid(flg_valid), .flg_out(flg_out)
    );

    // bench model state: expected outputs after the latest edge
    logic        m1v, m2v, m3v;
    logic [15:0] m_lo;
    logic [31:0] m_res, m_last, m2a, m2b, m1a, m1b;
    logic [3:0]  m_fl;
    string       t1, t2, t3;

    function automatic logic [3:0] exp_flags(input logic [31:0] a, input logic [31:0] b);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        return {s[31:0] == 32'd0, s[31], s[32], (a[31] == b[31]) && (s[31] != a[31])};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag,
                       input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk({31'd0, lo_valid}, {31'd0, m1v}, m1v ? t1 : "R7", "lo_valid");
        chk({16'd0, lo_sum}, {16'd0, m_lo}, m1v ? "R2" : "R7", "lo_sum");
        chk({31'd0, res_valid}, {31'd0, m2v}, m2v ? t2 : "R7", "res_valid");
        chk(res_sum, m_res, m2v ? t2 : "R7", "res_sum");
        chk({31'd0, flg_valid}, {31'd0, m3v}, m3v ? "R4" : "R7", "flg_valid");
        chk({28'd0, flg_out}, {28'd0, m_fl}, m3v ? t3 : "R7", "flg_out");
    endtask

    // one cycle: check state, drive next issue, advance the model
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input logic sa, input logic sb, input string tag);
        logic [31:0] ea, eb;
        @(negedge clk);
        check_outputs();
        iss_valid = v; iss_a = a; iss_b = b; iss_a_byp = sa; iss_b_byp = sb;
        if (m2v) m_fl = exp_flags(m2a, m2b);
        m3v = m2v; t3 = t2;
        if (m1v) begin m2a = m1a; m2b = m1b; m_res = m1a + m1b; end
        m2v = m1v; t2 = t1;
        if (v) begin
            ea = sa ? m_last : a;
            eb = sb ? m_last : b;
            m1a = ea; m1b = eb;
            m_lo = ea[15:0] + eb[15:0];
            m_last = ea + eb;
        end
        m1v = v; t1 = tag;
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; iss_valid = 1'b0; iss_a = '0; iss_b = '0;
        iss_a_byp = 1'b0; iss_b_byp = 1'b0;
        m1v = 0; m2v = 0; m3v = 0; m_lo = '0; m_res = '0; m_last = '0;
        m1a = '0; m1b = '0; m2a = '0; m2b = '0; m_fl = '0;
        t1 = "R2"; t2 = "R3"; t3 = "R4";
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({29'd0, lo_valid, res_valid, flg_valid}, 32'd0, "R1", "valids in reset");
        chk({lo_sum, 16'd0} | res_sum | {28'd0, flg_out}, 32'd0, "R1", "data in reset");
        rst = 1'b0;
        step(0, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, "R1");
        step(0, '0, '0, 0, 0, "R1");
        // R5: forwarding before any issue gives zero
        step(1, 32'hFFFF_FFFF, 32'h0000_0005, 1, 0, "R5");
        // R9: carry across the halves, all-ones wrap
        step(1, 32'h0000_FFFF, 32'h0000_0001, 0, 0, "R9");
        step(1, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, "R9");
        step(1, 32'h1234_8000, 32'h0000_8000, 0, 0, "R9");
        // R4: signed overflow, both directions
        step(1, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, "R4");
        step(1, 32'h8000_0000, 32'h8000_0000, 0, 0, "R4");
        // R6: back-to-back dependent chain
        step(1, 32'h0000_F005, 32'h0000_0FFB, 0, 0, "R6");
        for (int i = 0; i < 8; i++)
            step(1, 32'h0, 32'h0001_7FFF * (i + 1), 1, 0, "R6");
        // R8: doubling with both selects
        step(1, 32'h0000_C001, 32'h0, 0, 0, "R8");
        for (int i = 0; i < 6; i++) step(1, '0, '0, 1, 1, "R8");
        // R7 then R5: idle gap with junk inputs, forward across it
        step(1, 32'h1111_FFFF, 32'h2222_0001, 0, 0, "R5");
        for (int i = 0; i < 4; i++) step(0, $urandom, $urandom, 1, 1, "R7");
        step(1, 32'h5555_5555, 32'h0000_0010, 0, 1, "R5");
        step(1, 32'h0, 32'h0, 0, 0, "R4");
        // random stream
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom; rb = $urandom;
            if ($urandom % 8 == 0) ra = 32'hFFFF_FFFF;
            if ($urandom % 8 == 0) rb = 32'h0000_0001;
            if ($urandom % 10 == 0) ra = 32'h7FFF_0000 | (ra & 32'hFFFF);
            step($urandom % 4 != 0, ra, rb, $urandom % 2 == 0, $urandom % 3 == 0, "R5");
        end
        for (int i = 0; i < 4; i++) step(0, '0, '0, 0, 0, "R7");
        @(negedge clk);
        check_outputs();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule